// File: doc/BRIEF.md
# Sampling Clock Controller Register Block

This block holds the control and status registers of a delay-tap sampling clock controller in an SD host. A host processor reaches it over a simple single-cycle register bus. Through it the host enables the tap logic, programs the tap count, chooses a tap position and a data-to-flip-flop position, switches the sampling clock from the default clock to the tuned clock, and arms automatic re-tuning.

The block drives the delay line's controls straight from these registers. The tap position is limited to the programmed tap range before it leaves the block. The delay line reports a re-tune error as a one-cycle pulse, and the block stores it in a sticky flag. Software reads the flag and clears it by writing zero to the request register. The error is passed upward only while automatic re-tuning is armed.

Top module: `scc_regs`

## Requirements
- R1: After reset every register field reads zero, except the tap count field, which reads 8. The tap control register therefore reads 0x0008_0000 and every output is zero.
- R2: Register n is at byte address (2*n) << BUS_SHIFT. The registers, with n from 0 to 5, are tap control, tap set, data-to-flip-flop, clock select, re-tune control and re-tune request. Any other address, including one that is misaligned to the shift, reads zero and ignores writes. Read data is zero unless req_i is high and we_i is low.
- R3: Tap control bit 0 is the tap enable and drives tap_en_o. Bits 23:16 hold the 8-bit tap count. All other bits read zero.
- R4: Bits 7:0 of the tap set register and bits 7:0 of the data-to-flip-flop register are read/write. The data-to-flip-flop value drives dt2ff_o. All other bits read zero.
- R5: Clock select bit 0 drives clk_sel_o. A value of 1 selects the tuned sampling clock and 0 selects the default clock. All other bits read zero.
- R6: Re-tune control bit 0 drives retune_en_o. All other bits read zero.
- R7: A one-cycle pulse on err_pulse_i sets the sticky error flag at the next clock edge. The flag reads at bit 2 of the re-tune request register, and that register's other bits read zero.
- R8: Writing zero to the re-tune request register clears the flag. A nonzero write leaves it unchanged. If an error pulse and a clearing write arrive in the same cycle, the flag stays set.
- R9: retune_err_o is high exactly when the error flag and the re-tune enable are both set.
- R10: tap_sel_o equals the tap set value when that value is less than the tap count. Otherwise it equals the tap count minus one. It is 0 when the tap count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| err_pulse_i | input | 1 | One-cycle re-tune error from the delay line |
| tap_en_o | output | 1 | Tap logic enable |
| tap_sel_o | output | TAP_W | Tap position, limited to the tap range |
| dt2ff_o | output | TAP_W | Data-to-flip-flop position |
| clk_sel_o | output | 1 | 1 selects the tuned sampling clock |
| retune_en_o | output | 1 | Automatic re-tuning armed |
| retune_err_o | output | 1 | Qualified re-tune error |

## Verification
Every register feeds an output pin or the read port without delay, so a wrong register or decode state shows on the first read or output sample after the access that caused it. A lost or wrongly cleared error flag appears at bit 2 of the request register in the cycle after the pulse or the write. On retune_err_o it appears only once re-tuning is armed. A wrong limit on the tap position shows on tap_sel_o as soon as the tap set value reaches the tap count.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int NUM_REGS   = 6;
  localparam int IDX_TAPCTL = 0;
  localparam int IDX_TAPSET = 1;
  localparam int IDX_DTFF   = 2;
  localparam int IDX_CKSEL  = 3;
  localparam int IDX_RVCTL  = 4;
  localparam int IDX_RVREQ  = 5;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 8;
  localparam int CNT_LSB    = 16;
  localparam int ERR_BIT    = 2;
endpackage

// File: rtl/scc_addr_dec.sv
module scc_addr_dec import scc_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int BUS_SHIFT = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << BUS_SHIFT) - 1);

  logic              aligned;
  logic [ADDR_W-1:0] word_off;

  assign aligned  = (addr_i & LOW_MASK) == '0;
  assign word_off = addr_i >> BUS_SHIFT;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = aligned && (word_off == ADDR_W'(2 * i));
  end
endmodule

// File: rtl/scc_err_flag.sv
module scc_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set dominates a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/scc_tap_clamp.sv
module scc_tap_clamp #(
  parameter int TAP_W = 8,
  parameter int CNT_W = 8
) (
  input  logic [TAP_W-1:0] set_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [TAP_W-1:0] sel_o
);
  localparam int CMP_W = (TAP_W > CNT_W) ? TAP_W : CNT_W;

  logic [CMP_W-1:0] s_ext, c_ext;

  assign s_ext = CMP_W'(set_i);
  assign c_ext = CMP_W'(cnt_i);

  always_comb begin
    if (c_ext == '0)        sel_o = '0;
    else if (s_ext >= c_ext) sel_o = TAP_W'(c_ext - CMP_W'(1));
    else                    sel_o = set_i;
  end
endmodule

// File: rtl/scc_regs.sv
module scc_regs import scc_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int BUS_SHIFT = 2,
  parameter int TAP_W     = 8,
  parameter int CNT_RESET = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              err_pulse_i,
  output logic              tap_en_o,
  output logic [TAP_W-1:0]  tap_sel_o,
  output logic [TAP_W-1:0]  dt2ff_o,
  output logic              clk_sel_o,
  output logic              retune_en_o,
  output logic              retune_err_o
);
  logic [NUM_REGS-1:0] reg_sel, wr_sel;
  logic                tap_en_q, ck_sel_q, rv_en_q, err_flag_q, err_clr;
  logic [CNT_W-1:0]    tap_cnt_q;
  logic [TAP_W-1:0]    tap_set_q, dt2ff_q;
  logic [DATA_W-1:0]   rd_mux;

  scc_addr_dec #(.ADDR_W(ADDR_W), .BUS_SHIFT(BUS_SHIFT)) u_dec (
    .addr_i (addr_i),
    .sel_o  (reg_sel)
  );

  assign wr_sel = reg_sel & {NUM_REGS{req_i & we_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_en_q  <= 1'b0;
      tap_cnt_q <= CNT_W'(CNT_RESET);
      tap_set_q <= '0;
      dt2ff_q   <= '0;
      ck_sel_q  <= 1'b0;
      rv_en_q   <= 1'b0;
    end else begin
      if (wr_sel[IDX_TAPCTL]) begin
        tap_en_q  <= wdata_i[0];
        tap_cnt_q <= wdata_i[CNT_LSB +: CNT_W];
      end
      if (wr_sel[IDX_TAPSET]) tap_set_q <= wdata_i[TAP_W-1:0];
      if (wr_sel[IDX_DTFF])   dt2ff_q   <= wdata_i[TAP_W-1:0];
      if (wr_sel[IDX_CKSEL])  ck_sel_q  <= wdata_i[0];
      if (wr_sel[IDX_RVCTL])  rv_en_q   <= wdata_i[0];
    end
  end

  assign err_clr = wr_sel[IDX_RVREQ] && (wdata_i == '0);

  scc_err_flag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_pulse_i),
    .clr_i  (err_clr),
    .flag_o (err_flag_q)
  );

  scc_tap_clamp #(.TAP_W(TAP_W), .CNT_W(CNT_W)) u_clamp (
    .set_i (tap_set_q),
    .cnt_i (tap_cnt_q),
    .sel_o (tap_sel_o)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_sel[IDX_TAPCTL]) begin
      rd_mux[0]                = tap_en_q;
      rd_mux[CNT_LSB +: CNT_W] = tap_cnt_q;
    end
    if (reg_sel[IDX_TAPSET]) rd_mux[TAP_W-1:0] = tap_set_q;
    if (reg_sel[IDX_DTFF])   rd_mux[TAP_W-1:0] = dt2ff_q;
    if (reg_sel[IDX_CKSEL])  rd_mux[0]         = ck_sel_q;
    if (reg_sel[IDX_RVCTL])  rd_mux[0]         = rv_en_q;
    if (reg_sel[IDX_RVREQ])  rd_mux[ERR_BIT]   = err_flag_q;
  end

  assign rdata_o      = (req_i && !we_i) ? rd_mux : '0;
  assign tap_en_o     = tap_en_q;
  assign dt2ff_o      = dt2ff_q;
  assign clk_sel_o    = ck_sel_q;
  assign retune_en_o  = rv_en_q;
  assign retune_err_o = rv_en_q & err_flag_q;
endmodule

// File: rtl/scc_regs_chk.sv
module scc_regs_chk import scc_pkg::*; #(
  parameter int TAP_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                err_pulse_i,
  input logic [NUM_REGS-1:0] reg_sel,
  input logic                err_flag_q,
  input logic [CNT_W-1:0]    tap_cnt_q,
  input logic [TAP_W-1:0]    tap_sel_o,
  input logic                retune_en_o,
  input logic                retune_err_o
);
  AST_ERR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retune_err_o |-> retune_en_o); // R9
  AST_ERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_i |=> err_flag_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_q && !(req_i && we_i && reg_sel[IDX_RVREQ] && wdata_i == '0)) |=> err_flag_q); // R8
  AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_pulse_i && req_i && we_i && reg_sel[IDX_RVREQ] && wdata_i == '0) |=> !err_flag_q); // R8
  AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_cnt_q != '0) |-> ({{(32-TAP_W){1'b0}}, tap_sel_o} < {{(32-CNT_W){1'b0}}, tap_cnt_q})); // R10
  AST_DEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_sel)); // R2
endmodule

bind scc_regs scc_regs_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .wdata_i      (wdata_i),
  .err_pulse_i  (err_pulse_i),
  .reg_sel      (reg_sel),
  .err_flag_q   (err_flag_q),
  .tap_cnt_q    (tap_cnt_q),
  .tap_sel_o    (tap_sel_o),
  .retune_en_o  (retune_en_o),
  .retune_err_o (retune_err_o)
);

// File: tb/sim_scc_regs.sv
module sim_scc_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int BS     = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, err_pulse_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        tap_en_o, clk_sel_o, retune_en_o, retune_err_o;
  logic [7:0]  tap_sel_o, dt2ff_o;

  int checks = 0, errors = 0;

  // reference state
  logic       m_en, m_ck, m_rv, m_flag;
  logic [7:0] m_cnt, m_set, m_dt;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  scc_regs #(.ADDR_W(ADDR_W), .BUS_SHIFT(BS)) u0 (.*);

  function automatic logic [7:0] ra(int idx);
    return 8'((2 * idx) << BS);
  endfunction

  function automatic logic [31:0] exp_rd(int idx);
    case (idx)
      0: return {8'h0, m_cnt, 15'h0, m_en};
      1: return {24'h0, m_set};
      2: return {24'h0, m_dt};
      3: return {31'h0, m_ck};
      4: return {31'h0, m_rv};
      5: return {29'h0, m_flag, 2'b0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_sel();
    if (m_cnt == 0) return 8'h0;
    if (m_set >= m_cnt) return m_cnt - 8'd1;
    return m_set;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_ck = 0; m_rv = 0; m_flag = 0;
    m_cnt = 8'd8; m_set = 0; m_dt = 0;
  endtask

  // one clock: optional write to index idx (-1 none, raw addr when misaligned), optional pulse
  task automatic cyc(bit do_wr, logic [7:0] a, int idx, logic [31:0] d, bit pulse);
    bit clr;
    @(negedge clk_i);
    req_i = do_wr; we_i = do_wr; addr_i = a; wdata_i = d; err_pulse_i = pulse;
    @(posedge clk_i);
    #1;
    req_i = 0; we_i = 0; err_pulse_i = 0;
    clr = 0;
    if (do_wr) begin
      case (idx)
        0: begin m_en = d[0]; m_cnt = d[23:16]; end
        1: m_set = d[7:0];
        2: m_dt = d[7:0];
        3: m_ck = d[0];
        4: m_rv = d[0];
        5: clr = (d == 0);
        default: ;
      endcase
    end
    m_flag = pulse | (m_flag & ~clr);
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, int idx);
    req_i = 1; we_i = 0; addr_i = a;
    #1;
    check(tag, rdata_o, exp_rd(idx));
    req_i = 0;
    #1;
  endtask

  task automatic out_chk(string tag);
    check({tag, " R3 tap_en"}, {31'h0, tap_en_o}, {31'h0, m_en});
    check({tag, " R10 tap_sel"}, {24'h0, tap_sel_o}, {24'h0, exp_sel()});
    check({tag, " R4 dt2ff"}, {24'h0, dt2ff_o}, {24'h0, m_dt});
    check({tag, " R5 clk_sel"}, {31'h0, clk_sel_o}, {31'h0, m_ck});
    check({tag, " R6 retune_en"}, {31'h0, retune_en_o}, {31'h0, m_rv});
    check({tag, " R9 retune_err"}, {31'h0, retune_err_o}, {31'h0, m_rv & m_flag});
  endtask

  task automatic all_chk(string tag);
    for (int i = 0; i < 6; i++) rd_chk({tag, " R2 readback"}, ra(i), i);
    out_chk(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1;
    #2;
    // R1 reset state
    rd_chk("R1 tapctl reset", ra(0), 0);
    check("R1 tapctl value", exp_rd(0), 32'h0008_0000);
    all_chk("R1");

    // R3 field masking
    cyc(1, ra(0), 0, 32'hFFFF_FFFF, 0);
    rd_chk("R3 tapctl mask", ra(0), 0);
    check("R3 model", exp_rd(0), 32'h00FF_0001);
    // R4/R5/R6 masking
    cyc(1, ra(1), 1, 32'hABCD_EF12, 0);
    cyc(1, ra(2), 2, 32'h1234_5678, 0);
    cyc(1, ra(3), 3, 32'hFFFF_FFFF, 0);
    cyc(1, ra(4), 4, 32'hFFFF_FFFE, 0);
    all_chk("R4 R5 R6");

    // R10 clamp corners
    cyc(1, ra(0), 0, 32'h0008_0001, 0);
    cyc(1, ra(1), 1, 32'd12, 0);
    check("R10 clamp high", {24'h0, tap_sel_o}, 32'd7);
    cyc(1, ra(1), 1, 32'd8, 0);
    check("R10 clamp at count", {24'h0, tap_sel_o}, 32'd7);
    cyc(1, ra(1), 1, 32'd5, 0);
    check("R10 in range", {24'h0, tap_sel_o}, 32'd5);
    cyc(1, ra(0), 0, 32'h0000_0001, 0);
    check("R10 zero count", {24'h0, tap_sel_o}, 32'd0);
    cyc(1, ra(0), 0, 32'h0008_0000, 0);

    // R7 R8 R9 error flag
    cyc(1, ra(4), 4, 32'h0, 0);
    cyc(0, 8'h0, -1, 0, 1);
    rd_chk("R7 flag set", ra(5), 5);
    check("R7 flag bit2", exp_rd(5), 32'h4);
    check("R9 gated off", {31'h0, retune_err_o}, 32'h0);
    cyc(1, ra(4), 4, 32'h1, 0);
    check("R9 gated on", {31'h0, retune_err_o}, 32'h1);
    cyc(1, ra(5), 5, 32'h4, 0);
    rd_chk("R8 nonzero keeps", ra(5), 5);
    cyc(1, ra(5), 5, 32'h0, 1);
    rd_chk("R8 set wins", ra(5), 5);
    check("R8 set wins out", {31'h0, retune_err_o}, 32'h1);
    cyc(1, ra(5), 5, 32'h0, 0);
    rd_chk("R8 cleared", ra(5), 5);
    check("R8 cleared out", {31'h0, retune_err_o}, 32'h0);

    // R2 undefined and misaligned addresses
    cyc(1, 8'h30, -1, 32'hFFFF_FFFF, 0);
    cyc(1, 8'h01, -1, 32'hFFFF_FFFF, 0);
    cyc(1, 8'h04, -1, 32'hFFFF_FFFF, 0);
    rd_chk("R2 undef read", 8'h30, -1);
    rd_chk("R2 misaligned read", 8'h01, -1);
    rd_chk("R2 half-step read", 8'h04, -1);
    all_chk("R2 ignored writes");
    req_i = 0; we_i = 1; addr_i = ra(0); #1;
    check("R2 no read data on write", rdata_o, 32'h0);
    we_i = 0; #1;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [31:0] d;
      bit p, w;
      idx = $urandom_range(0, 7);
      d = $urandom;
      if ($urandom_range(0, 1) == 1) d = d & 32'h00FF_00FF;
      if (idx == 5 && $urandom_range(0, 1) == 1) d = 0;
      w = ($urandom_range(0, 3) != 0);
      p = ($urandom_range(0, 4) == 0);
      cyc(w, ra(idx), idx, d, p);
      rd_chk("R2 R7 rand read", ra(n % 6), n % 6);
      out_chk("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule